// File: doc/BRIEF.md
# Decode-Stage Interlock Unit

This block is the hazard-detection control for a five-stage, in-order integer pipeline that has no forwarding paths. It looks at the instruction sitting in decode and works out, from its major opcode, which of its two source operands are actually read. It then compares each of those source indices with the destination index of every instruction still in flight in execute, memory and writeback. Only stages whose write-enable is set take part in the comparison.

When a read operand matches a pending write, the unit raises a stall. The fetch and decode registers hold their contents, and an empty slot is loaded into execute. That empty slot has its write-enable and destination cleared, so it never matches anything later on. When there is no stall, the unit passes the decode instruction's own write-enable and destination index on toward execute. These then become that stage's comparison inputs in later cycles.

The unit is purely combinational, so all of its outputs follow the current inputs in the same cycle. A store followed by a load to the same address needs no handling here, because the memory system completes a write in one cycle.

Top module: `hzd_interlock`

## Requirements
- R1: Source 1 counts as read for opcodes 7'b0110011 (register ALU), 7'b0010011 (immediate ALU), 7'b0000011 (load), 7'b0100011 (store), 7'b1100011 (branch) and 7'b1100111 (indirect jump). It does not count as read for 7'b1101111 (direct jump with link), so a match on source 1 stalls only for the first six.
- R2: Source 2 counts as read only for register ALU, store and branch. A match on source 2 stalls only for those three.
- R3: With no stall, ex_wen_o is 1 for register ALU, immediate ALU, load, direct jump and indirect jump, and 0 for store and branch. ex_rd_o equals dec_rd_i.
- R4: stall_o is 1 whenever a read source index equals the destination of an enabled stage. This holds for stage 0 (execute), stage 1 (memory) and stage 2 (writeback) alike, and for several matches at once.
- R5: A stage whose write-enable is 0 never causes a stall, whatever its destination index.
- R6: A destination index of 0 never causes a stall.
- R7: While stall_o is 1, fd_hold_o and ex_bubble_o are 1, and ex_wen_o and ex_rd_o are 0. While stall_o is 0, fd_hold_o and ex_bubble_o are 0.
- R8: Any other opcode reads and writes nothing: it never stalls and presents ex_wen_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_opcode_i | input | 7 | Major opcode of the decode-stage instruction |
| dec_rd_i | input | IDX_W | Destination index of the decode-stage instruction |
| dec_rs1_i | input | IDX_W | Source 1 index of the decode-stage instruction |
| dec_rs2_i | input | IDX_W | Source 2 index of the decode-stage instruction |
| stg_rd_i | input | NUM_STG x IDX_W | Destination index per downstream stage (0 = execute) |
| stg_wen_i | input | NUM_STG | Write-enable per downstream stage |
| stall_o | output | 1 | A true dependence exists |
| fd_hold_o | output | 1 | Hold the fetch and decode registers |
| ex_bubble_o | output | 1 | Load an empty slot into execute |
| ex_wen_o | output | 1 | Write-enable to load into execute |
| ex_rd_o | output | IDX_W | Destination index to load into execute |

## Verification
Every result is due in the same cycle as the stimulus that produces it, because no register lies between inputs and outputs. The bench applies each input pattern on a falling clock edge. It samples all outputs one nanosecond later, well before the next rising edge, so no check straddles an input change. The sweep covers each opcode class against every stage, each operand, zero and non-zero destinations, and both write-enable values. Directed cases then add several simultaneous matches.

// File: rtl/hzd_pkg.sv
// Package: shared opcode encodings and the operand-usage record for the
// interlock unit. Assumes the 7-bit major opcode field of a 32-bit word.
package hzd_pkg;

    localparam int OPC_W = 7;

    localparam logic [OPC_W-1:0] OPC_ALU_REG = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_ALU_IMM = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD    = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE   = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH  = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JMP_DIR = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JMP_IND = 7'b1100111;

    // Which register-file accesses an instruction performs.
    typedef struct packed {
        logic use_src1;
        logic use_src2;
        logic writes_dst;
    } opnd_use_t;

endpackage

// File: rtl/hzd_opdecode.sv
// Module: maps a major opcode onto its operand usage.
// Assumes unknown opcodes touch no register.
module hzd_opdecode
    import hzd_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output opnd_use_t        use_o
);

    // Opcode classification into read and write enables.
    always_comb begin
        use_o = '0;
        unique case (opcode_i)
            OPC_ALU_REG: use_o = '{use_src1: 1'b1, use_src2: 1'b1, writes_dst: 1'b1};
            OPC_ALU_IMM: use_o = '{use_src1: 1'b1, use_src2: 1'b0, writes_dst: 1'b1};
            OPC_LOAD:    use_o = '{use_src1: 1'b1, use_src2: 1'b0, writes_dst: 1'b1};
            OPC_STORE:   use_o = '{use_src1: 1'b1, use_src2: 1'b1, writes_dst: 1'b0};
            OPC_BRANCH:  use_o = '{use_src1: 1'b1, use_src2: 1'b1, writes_dst: 1'b0};
            OPC_JMP_DIR: use_o = '{use_src1: 1'b0, use_src2: 1'b0, writes_dst: 1'b1};
            OPC_JMP_IND: use_o = '{use_src1: 1'b1, use_src2: 1'b0, writes_dst: 1'b1};
            default:     use_o = '0;
        endcase
    end

endmodule

// File: rtl/hzd_stage_cmp.sv
// Module: one operand-versus-stage dependence comparator.
// Assumes index 0 is the hard-wired zero register and is never written.
module hzd_stage_cmp #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx_i,
    input  logic             src_en_i,
    input  logic [IDX_W-1:0] dst_idx_i,
    input  logic             dst_wen_i,
    output logic             hit_o
);

    logic dst_live;

    // A pending write counts only when enabled and aimed at a real register.
    assign dst_live = dst_wen_i && (dst_idx_i != '0);

    // Dependence when the operand is read and its index matches.
    assign hit_o = src_en_i && dst_live && (src_idx_i == dst_idx_i);

endmodule

// File: rtl/hzd_interlock.sv
// Module: decode-stage interlock for an in-order pipeline without
// forwarding. Compares read operands of the decode instruction against
// destinations of NUM_STG downstream stages (0 = execute) and produces
// hold and bubble controls. Purely combinational.
module hzd_interlock
    import hzd_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_STG = 3
) (
    input  logic [OPC_W-1:0]              dec_opcode_i,
    input  logic [IDX_W-1:0]              dec_rd_i,
    input  logic [IDX_W-1:0]              dec_rs1_i,
    input  logic [IDX_W-1:0]              dec_rs2_i,
    input  logic [NUM_STG-1:0][IDX_W-1:0] stg_rd_i,
    input  logic [NUM_STG-1:0]            stg_wen_i,
    output logic                          stall_o,
    output logic                          fd_hold_o,
    output logic                          ex_bubble_o,
    output logic                          ex_wen_o,
    output logic [IDX_W-1:0]              ex_rd_o
);

    localparam int NUM_SRC = 2;

    opnd_use_t                            dec_use;
    logic [NUM_SRC-1:0][IDX_W-1:0]        src_idx;
    logic [NUM_SRC-1:0]                   src_en;
    logic [NUM_SRC-1:0][NUM_STG-1:0]      hit;

    hzd_opdecode u_dec (
        .opcode_i (dec_opcode_i),
        .use_o    (dec_use)
    );

    // Gather both source operands with their read enables.
    assign src_idx = {dec_rs2_i, dec_rs1_i};
    assign src_en  = {dec_use.use_src2, dec_use.use_src1};

    // One comparator per operand and downstream stage.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar p = 0; p < NUM_STG; p++) begin : g_stg
            hzd_stage_cmp #(.IDX_W(IDX_W)) u_cmp (
                .src_idx_i (src_idx[s]),
                .src_en_i  (src_en[s]),
                .dst_idx_i (stg_rd_i[p]),
                .dst_wen_i (stg_wen_i[p]),
                .hit_o     (hit[s][p])
            );
        end
    end

    // Any dependence freezes the front end.
    assign stall_o     = |hit;
    assign fd_hold_o   = stall_o;
    assign ex_bubble_o = stall_o;

    // Execute-stage load: the decode instruction, or an empty slot.
    always_comb begin
        if (stall_o) begin
            ex_wen_o = 1'b0;
            ex_rd_o  = '0;
        end else begin
            ex_wen_o = dec_use.writes_dst;
            ex_rd_o  = dec_rd_i;
        end
    end

endmodule

// File: rtl/hzd_interlock_chk.sv
// Module: assertion checker bound to the interlock unit. Uses immediate
// assertions because the unit has no clock.
module hzd_interlock_chk
    import hzd_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_STG = 3
) (
    input logic [OPC_W-1:0]   dec_opcode_i,
    input logic [NUM_STG-1:0] stg_wen_i,
    input logic               stall_o,
    input logic               fd_hold_o,
    input logic               ex_bubble_o,
    input logic               ex_wen_o,
    input logic [IDX_W-1:0]   ex_rd_o
);

    logic known_writer;
    logic known_op;

    // Opcode classes as seen by the checker.
    assign known_writer = (dec_opcode_i == OPC_ALU_REG) || (dec_opcode_i == OPC_ALU_IMM) ||
                          (dec_opcode_i == OPC_LOAD)    || (dec_opcode_i == OPC_JMP_DIR) ||
                          (dec_opcode_i == OPC_JMP_IND);
    assign known_op     = known_writer || (dec_opcode_i == OPC_STORE) ||
                          (dec_opcode_i == OPC_BRANCH);

    // Immediate checks on the settled combinational outputs.
    always_comb begin
        AST_STALL_NEEDS_WRITER: assert (!stall_o || (|stg_wen_i)); // R5
        AST_DIRECT_JUMP_NO_STALL: assert (!(dec_opcode_i == OPC_JMP_DIR) || !stall_o); // R1
        AST_BUBBLE_EMPTY: assert (!stall_o || (!ex_wen_o && ex_rd_o == '0 && fd_hold_o && ex_bubble_o)); // R7
        AST_WRITER_PASSES: assert (stall_o || !known_writer || ex_wen_o); // R3
        AST_NONWRITER_QUIET: assert (known_writer || !ex_wen_o); // R3
        AST_UNKNOWN_NO_STALL: assert (known_op || !stall_o); // R8
    end

endmodule

bind hzd_interlock hzd_interlock_chk #(.IDX_W(IDX_W), .NUM_STG(NUM_STG)) u_chk (
    .dec_opcode_i (dec_opcode_i),
    .stg_wen_i    (stg_wen_i),
    .stall_o      (stall_o),
    .fd_hold_o    (fd_hold_o),
    .ex_bubble_o  (ex_bubble_o),
    .ex_wen_o     (ex_wen_o),
    .ex_rd_o      (ex_rd_o)
);

// File: tb/test_hzd_interlock.sv
module test_hzd_interlock;

    localparam int IDX_W   = 5;
    localparam int NUM_STG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0]                    opc;
    logic [IDX_W-1:0]              rd, rs1, rs2;
    logic [NUM_STG-1:0][IDX_W-1:0] srd;
    logic [NUM_STG-1:0]            swen;
    logic                          stall, hold, bubble, exw;
    logic [IDX_W-1:0]              exrd;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hzd_interlock #(.IDX_W(IDX_W), .NUM_STG(NUM_STG)) i_hzd_interlock (
        .dec_opcode_i (opc), .dec_rd_i (rd), .dec_rs1_i (rs1), .dec_rs2_i (rs2),
        .stg_rd_i (srd), .stg_wen_i (swen), .stall_o (stall), .fd_hold_o (hold),
        .ex_bubble_o (bubble), .ex_wen_o (exw), .ex_rd_o (exrd)
    );

    function automatic logic [6:0] opc_of(int k);
        case (k)
            0: return 7'b0110011; 1: return 7'b0010011; 2: return 7'b0000011;
            3: return 7'b0100011; 4: return 7'b1100011; 5: return 7'b1101111;
            6: return 7'b1100111; default: return 7'b1110011;
        endcase
    endfunction
    // Reads of source 1 / source 2 and destination write, per class.
    function automatic bit re1_of(int k); return (k <= 4) || (k == 6); endfunction
    function automatic bit re2_of(int k); return (k == 0) || (k == 3) || (k == 4); endfunction
    function automatic bit we_of(int k);  return (k <= 2) || (k == 5) || (k == 6); endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag, bit exp_stall, int k);
        check(tag, stall, exp_stall);
        check("R7", {hold, bubble}, exp_stall ? 2'b11 : 2'b00);
        check(exp_stall ? "R7" : "R3", exw, exp_stall ? 1'b0 : we_of(k));
        check(exp_stall ? "R7" : "R3", exrd, exp_stall ? '0 : rd);
    endtask

    initial begin
        opc = '0; rd = '0; rs1 = '0; rs2 = '0; srd = '0; swen = '0;
        repeat (3) @(negedge clk);
        #1 check("R8", {stall, hold, bubble, exw}, 4'b0000); // reset-time idle inputs
        rst_n = 1'b1;
        // Sweep: class x stage x operand select x destination x enable.
        for (int k = 0; k < 8; k++)
            for (int p = 0; p < NUM_STG; p++)
                for (int sel = 0; sel < 3; sel++)
                    for (int d = 0; d < 3; d++)
                        for (int w = 0; w < 2; w++) begin
                            logic [IDX_W-1:0] dv;
                            bit exp;
                            string tag;
                            @(negedge clk);
                            dv = (d == 0) ? 5'd0 : (d == 1) ? 5'd3 : 5'd31;
                            opc = opc_of(k); rd = 5'd7;
                            srd = '0; swen = '0;
                            srd[p] = dv; swen[p] = w[0];
                            rs1 = (sel == 1) ? dv : 5'd12;
                            rs2 = (sel == 2) ? dv : 5'd13;
                            exp = w[0] && (dv != 0) &&
                                  ((sel == 1 && re1_of(k)) || (sel == 2 && re2_of(k)));
                            if (k == 7)        tag = "R8";
                            else if (w == 0)   tag = "R5";
                            else if (dv == 0)  tag = "R6";
                            else if (sel == 1) tag = "R1";
                            else if (sel == 2) tag = "R2";
                            else               tag = "R4";
                            #1 check_outs(tag, exp, k);
                        end
        // R4: multiple simultaneous matches across stages.
        @(negedge clk);
        opc = opc_of(0); rd = 5'd9; rs1 = 5'd4; rs2 = 5'd6;
        srd[0] = 5'd4; srd[1] = 5'd6; srd[2] = 5'd4; swen = 3'b111;
        #1 check_outs("R4", 1'b1, 0);
        // R4: writeback only, source 2 of a store.
        @(negedge clk);
        opc = opc_of(3); swen = 3'b100; srd[2] = 5'd6; srd[0] = 5'd6; srd[1] = 5'd6;
        #1 check_outs("R4", 1'b1, 3);
        // R5: all stages match but none is enabled.
        @(negedge clk);
        swen = 3'b000;
        #1 check_outs("R5", 1'b0, 3);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (20000) @(posedge clk); end
        join_any
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule